// File: doc/BRIEF.md
# Byte Transfer Counter with Residual Report

This block counts the bytes of one transfer in a SCSI-style protocol core. Software stages a start count through byte-wide registers, one byte per register. The registers sit on a four-byte address stride: the low byte at 0x0, the middle byte at 0x4 and the high byte at 0x8. The staged value goes into a working counter only when a DMA-type command is issued.

The working counter counts down by one for each byte that enters the internal FIFO from the DMA side. It does not count bytes as they leave the FIFO for the bus. A configuration input picks the counter width:

- **Narrow mode:** 16 bits. A staged zero means 65536 bytes.
- **Wide mode:** 24 bits. The high byte takes part, so a transfer can be up to 16 MiB minus one byte.

A terminal-count flag shows that the transfer ran out. The block also gives software a residual figure. Bytes still in the FIFO have already been taken off the counter, so the residual adds the FIFO occupancy to the remaining count. Reads at the register addresses return the bytes of the working counter.

Top module: `xfer_count_top`

## Requirements
- R1: After reset, `count_o` is 0, `tc_o` is 0, and `residual_o` equals `fifo_level_i`.
- R2: A register write changes only the staged bytes. `count_o` and `tc_o` keep their values until `load_cmd_i` is seen.
- R3: In narrow mode (`wide_en_i`=0), a load copies {middle, low} into the counter and clears `tc_o` on the next cycle. The staged high byte is ignored.
- R4: In narrow mode, a staged {middle, low} of zero loads the value 65536 (0x10000).
- R5: In wide mode (`wide_en_i`=1), a load copies {high, middle, low}. A staged zero in wide mode loads 0 and sets `tc_o` on the next cycle.
- R6: A `byte_stb_i` with no load in the same cycle lowers a nonzero count by one on the next cycle.
- R7: The strobe that takes the count from 1 to 0 sets `tc_o` on the next cycle. `tc_o` then stays set until the next load.
- R8: A strobe while the count is 0 is ignored: the count stays 0 and `tc_o` keeps its value.
- R9: When `load_cmd_i` and `byte_stb_i` are high in the same cycle, the load wins and the strobe is dropped.
- R10: `residual_o` always equals `count_o` plus `fifo_level_i`, without truncation.
- R11: `reg_rdata_o` returns the working counter byte k when `reg_addr_i` equals k*4, for k = 0, 1 or 2. Any other address reads 0.
- R12: A write to an address whose two low bits are nonzero, or whose index is above 2, changes no staged byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W (4) | Byte address, register index times 4 |
| reg_wdata_i | input | BYTE_W (8) | Write data |
| reg_rdata_o | output | BYTE_W (8) | Working counter byte at `reg_addr_i` |
| wide_en_i | input | 1 | 1 selects the 24-bit counter, 0 the 16-bit counter |
| load_cmd_i | input | 1 | DMA-type command issued; loads the staged count |
| byte_stb_i | input | 1 | One byte entered the FIFO |
| fifo_level_i | input | FIFO_W (5) | Bytes currently held in the FIFO |
| count_o | output | CNT_W (24) | Working counter value |
| tc_o | output | 1 | Terminal count reached |
| residual_o | output | CNT_W+1 (25) | Count plus FIFO occupancy |

## Verification
The bound checker watches every cycle for these properties:
- a single-step decrement;
- a count held at zero with the flag untouched;
- the flag rising on the 1-to-0 step and implying a zero count;
- a narrow load landing in the range 1 to 65536;
- the residual sum;
- a stable count when no load or strobe is present.

Some behaviours only the bench scenarios can show, because they depend on the staged values:
- which bytes a load actually picks up;
- the zero-means-65536 encoding, followed over a full 65536-strobe drain;
- the wide-mode zero load;
- load priority over a same-cycle strobe;
- writes to misaligned and out-of-range addresses being dropped.

// File: rtl/xfer_cnt_pkg.sv
package xfer_cnt_pkg;
  // register index is shifted left by this amount to form the byte address
  localparam int unsigned IDX_SHIFT = 2;

  typedef enum logic [1:0] {
    IDX_LOW  = 2'd0,
    IDX_MID  = 2'd1,
    IDX_HIGH = 2'd2
  } cnt_idx_e;
endpackage

// File: rtl/xc_stage.sv
module xc_stage #(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned NUM_BYTES = 3,
  parameter int unsigned ADDR_W    = 4,
  localparam int unsigned CNT_W    = BYTE_W * NUM_BYTES,
  localparam int unsigned IDX_W    = ADDR_W - xfer_cnt_pkg::IDX_SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  stage_o
);
  logic             aligned;
  logic [IDX_W-1:0] idx;

  assign aligned = (addr_i[xfer_cnt_pkg::IDX_SHIFT-1:0] == '0);
  assign idx     = addr_i[ADDR_W-1:xfer_cnt_pkg::IDX_SHIFT];

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
    logic hit;
    assign hit = we_i && aligned && (idx == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  stage_o[g*BYTE_W +: BYTE_W] <= '0;
      else if (hit) stage_o[g*BYTE_W +: BYTE_W] <= wdata_i;
    end
  end
endmodule

// File: rtl/xc_counter.sv
module xc_counter #(
  parameter int unsigned BYTE_W       = 8,
  parameter int unsigned NUM_BYTES    = 3,
  parameter int unsigned NARROW_BYTES = 2,
  localparam int unsigned CNT_W       = BYTE_W * NUM_BYTES,
  localparam int unsigned NARROW_W    = BYTE_W * NARROW_BYTES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             wide_i,
  input  logic [CNT_W-1:0] stage_i,
  input  logic             stb_i,
  output logic [CNT_W-1:0] count_o,
  output logic             tc_o
);
  localparam logic [CNT_W-1:0] NARROW_MAX = CNT_W'(1) << NARROW_W;

  logic [NARROW_W-1:0] narrow_val;
  logic [CNT_W-1:0]    load_val;
  logic                cnt_zero;

  assign narrow_val = stage_i[NARROW_W-1:0];
  assign cnt_zero   = (count_o == '0);

  always_comb begin
    if (wide_i)                 load_val = stage_i;
    else if (narrow_val == '0)  load_val = NARROW_MAX;  // zero encodes full 2^NARROW_W
    else                        load_val = CNT_W'(narrow_val);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o <= '0;
      tc_o    <= 1'b0;
    end else if (load_i) begin
      count_o <= load_val;
      tc_o    <= (load_val == '0);
    end else if (stb_i && !cnt_zero) begin
      count_o <= count_o - CNT_W'(1);
      if (count_o == CNT_W'(1)) tc_o <= 1'b1;
    end
  end
endmodule

// File: rtl/xc_readback.sv
module xc_readback #(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned NUM_BYTES = 3,
  parameter int unsigned ADDR_W    = 4,
  localparam int unsigned CNT_W    = BYTE_W * NUM_BYTES,
  localparam int unsigned IDX_W    = ADDR_W - xfer_cnt_pkg::IDX_SHIFT
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic [BYTE_W-1:0] rdata_o
);
  logic             aligned;
  logic [IDX_W-1:0] idx;

  assign aligned = (addr_i[xfer_cnt_pkg::IDX_SHIFT-1:0] == '0);
  assign idx     = addr_i[ADDR_W-1:xfer_cnt_pkg::IDX_SHIFT];

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_BYTES; i++) begin
      if (aligned && idx == IDX_W'(i)) rdata_o = count_i[i*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/xc_residual.sv
module xc_residual #(
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned FIFO_W = 5
) (
  input  logic [CNT_W-1:0]  count_i,
  input  logic [FIFO_W-1:0] fifo_level_i,
  output logic [CNT_W:0]    residual_o
);
  assign residual_o = (CNT_W+1)'(count_i) + (CNT_W+1)'(fifo_level_i);
endmodule

// File: rtl/xfer_count_top.sv
module xfer_count_top #(
  parameter int unsigned BYTE_W       = 8,
  parameter int unsigned NUM_BYTES    = 3,
  parameter int unsigned NARROW_BYTES = 2,
  parameter int unsigned ADDR_W       = 4,
  parameter int unsigned FIFO_W       = 5,
  localparam int unsigned CNT_W       = BYTE_W * NUM_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  output logic [BYTE_W-1:0] reg_rdata_o,
  input  logic              wide_en_i,
  input  logic              load_cmd_i,
  input  logic              byte_stb_i,
  input  logic [FIFO_W-1:0] fifo_level_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              tc_o,
  output logic [CNT_W:0]    residual_o
);
  logic [CNT_W-1:0] stage;

  xc_stage #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W)) u_stage (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .stage_o (stage)
  );

  xc_counter #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES), .NARROW_BYTES(NARROW_BYTES)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_cmd_i),
    .wide_i  (wide_en_i),
    .stage_i (stage),
    .stb_i   (byte_stb_i),
    .count_o (count_o),
    .tc_o    (tc_o)
  );

  xc_readback #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W)) u_rb (
    .addr_i  (reg_addr_i),
    .count_i (count_o),
    .rdata_o (reg_rdata_o)
  );

  xc_residual #(.CNT_W(CNT_W), .FIFO_W(FIFO_W)) u_res (
    .count_i      (count_o),
    .fifo_level_i (fifo_level_i),
    .residual_o   (residual_o)
  );
endmodule

// File: rtl/xfer_count_chk.sv
module xfer_count_chk #(
  parameter int unsigned BYTE_W       = 8,
  parameter int unsigned NUM_BYTES    = 3,
  parameter int unsigned NARROW_BYTES = 2,
  parameter int unsigned FIFO_W       = 5,
  localparam int unsigned CNT_W       = BYTE_W * NUM_BYTES,
  localparam int unsigned NARROW_W    = BYTE_W * NARROW_BYTES
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wide_en_i,
  input logic              load_cmd_i,
  input logic              byte_stb_i,
  input logic [FIFO_W-1:0] fifo_level_i,
  input logic [CNT_W-1:0]  count_o,
  input logic              tc_o,
  input logic [CNT_W:0]    residual_o
);
  localparam logic [CNT_W-1:0] NARROW_MAX = CNT_W'(1) << NARROW_W;

  a_r6_decrement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_stb_i && !load_cmd_i && count_o != '0) |=> (count_o == $past(count_o) - CNT_W'(1)));

  a_r7_tc_on_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_stb_i && !load_cmd_i && count_o == CNT_W'(1)) |=> tc_o);

  a_r7_tc_means_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> (count_o == '0));

  a_r8_hold_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_stb_i && !load_cmd_i && count_o == '0) |=> (count_o == '0 && tc_o == $past(tc_o)));

  a_r3_narrow_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_cmd_i && !wide_en_i) |=> (!tc_o && count_o != '0 && count_o <= NARROW_MAX));

  a_r2_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_cmd_i && !byte_stb_i) |=> ($stable(count_o) && $stable(tc_o)));

  a_r10_residual_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    residual_o == (CNT_W+1)'(count_o) + (CNT_W+1)'(fifo_level_i));
endmodule

bind xfer_count_top xfer_count_chk #(
  .BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES), .NARROW_BYTES(NARROW_BYTES), .FIFO_W(FIFO_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wide_en_i    (wide_en_i),
  .load_cmd_i   (load_cmd_i),
  .byte_stb_i   (byte_stb_i),
  .fifo_level_i (fifo_level_i),
  .count_o      (count_o),
  .tc_o         (tc_o),
  .residual_o   (residual_o)
);

// File: tb/xfer_count_top_test.sv
module xfer_count_top_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [3:0]  reg_addr_i = '0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic        wide_en_i = 1'b0;
  logic        load_cmd_i = 1'b0;
  logic        byte_stb_i = 1'b0;
  logic [4:0]  fifo_level_i = '0;
  logic [23:0] count_o;
  logic        tc_o;
  logic [24:0] residual_o;

  int total = 0;
  int bad = 0;

  xfer_count_top uut (.*);

  always #4ns clk_i = ~clk_i;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    tick();
    reg_we_i = 1'b0;
  endtask

  task automatic stage3(input logic [23:0] v);
    wr(4'h0, v[7:0]); wr(4'h4, v[15:8]); wr(4'h8, v[23:16]);
  endtask

  task automatic load();
    load_cmd_i = 1'b1; tick(); load_cmd_i = 1'b0;
  endtask

  task automatic strobe(input int n);
    byte_stb_i = 1'b1;
    repeat (n) tick();
    byte_stb_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
    reg_addr_i = a; #1ns;
    chk(tag, 32'(reg_rdata_o), 32'(exp));
  endtask

  initial begin
    #1600us;
    bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    chk("R1 count", 32'(count_o), 0);
    chk("R1 tc", 32'(tc_o), 0);
    fifo_level_i = 5'd9; #1ns;
    chk("R1 residual", 32'(residual_o), 9);
    fifo_level_i = 5'd0;

    // R8 strobe at zero after reset raises nothing
    strobe(3);
    chk("R8 count at zero", 32'(count_o), 0);
    chk("R8 no flag", 32'(tc_o), 0);

    // R2 staging alone does not touch the counter
    stage3(24'h070005);
    chk("R2 count unchanged", 32'(count_o), 0);
    chk("R2 tc unchanged", 32'(tc_o), 0);
    rd(4'h0, 8'h00, "R2 readback low");

    // R3 narrow load ignores high byte
    load();
    chk("R3 narrow load", 32'(count_o), 5);
    chk("R3 tc clear", 32'(tc_o), 0);
    rd(4'h8, 8'h00, "R11 high byte");

    // R6/R7 step-by-step drain for small counts
    for (int n = 1; n <= 8; n++) begin
      wr(4'h0, 8'(n)); wr(4'h4, 8'h00);
      load();
      for (int k = 1; k <= n; k++) begin
        strobe(1);
        chk("R6 decrement", 32'(count_o), 32'(n - k));
        chk("R7 tc timing", 32'(tc_o), (k == n) ? 1 : 0);
      end
      strobe(2);
      chk("R8 stays zero", 32'(count_o), 0);
      chk("R7 tc held", 32'(tc_o), 1);
    end

    // R3/R4 sweep of low and middle bytes in narrow mode
    for (int v = 0; v < 256; v++) begin
      wr(4'h0, 8'(v)); wr(4'h4, 8'h00);
      load();
      chk("R4 low sweep", 32'(count_o), (v == 0) ? 32'h10000 : 32'(v));
      chk("R3 tc clear sweep", 32'(tc_o), 0);
      wr(4'h0, 8'h00); wr(4'h4, 8'(v));
      load();
      chk("R4 mid sweep", 32'(count_o), (v == 0) ? 32'h10000 : 32'(v) << 8);
    end

    // R4 full drain of the 65536 encoding
    stage3(24'h550000);
    load();
    chk("R4 zero means 65536", 32'(count_o), 32'h10000);
    rd(4'h0, 8'h00, "R11 low of 65536");
    rd(4'h8, 8'h01, "R11 high of 65536");
    strobe(65535);
    chk("R4 one left", 32'(count_o), 1);
    chk("R4 no tc yet", 32'(tc_o), 0);
    strobe(1);
    chk("R7 tc after 65536", 32'(tc_o), 1);
    chk("R4 drained", 32'(count_o), 0);

    // R5 wide mode
    wide_en_i = 1'b1;
    stage3(24'h123456);
    load();
    chk("R5 wide load", 32'(count_o), 32'h123456);
    chk("R7 load clears tc", 32'(tc_o), 0);
    rd(4'h0, 8'h56, "R11 low");
    rd(4'h4, 8'h34, "R11 mid");
    rd(4'h8, 8'h12, "R11 high");
    rd(4'hC, 8'h00, "R11 index 3");
    rd(4'h5, 8'h00, "R11 misaligned");
    stage3(24'h000000);
    load();
    chk("R5 wide zero count", 32'(count_o), 0);
    chk("R5 wide zero tc", 32'(tc_o), 1);

    // R9 load beats strobe
    wr(4'h0, 8'd10);
    load_cmd_i = 1'b1; byte_stb_i = 1'b1;
    tick();
    load_cmd_i = 1'b0; byte_stb_i = 1'b0;
    chk("R9 load wins", 32'(count_o), 10);

    // R10 residual sweep over all FIFO levels, including the top count
    for (int c = 0; c < 3; c++) begin
      logic [23:0] cv;
      cv = (c == 0) ? 24'h000001 : (c == 1) ? 24'h00ABCD : 24'hFFFFFF;
      stage3(cv);
      load();
      for (int f = 0; f < 32; f++) begin
        fifo_level_i = 5'(f); #1ns;
        chk("R10 residual", 32'(residual_o), 32'(cv) + 32'(f));
      end
    end
    fifo_level_i = '0;

    // R12 off-stride and out-of-range writes dropped
    stage3(24'h332211);
    wr(4'h1, 8'hFF); wr(4'h2, 8'hEE); wr(4'h3, 8'hDD);
    wr(4'hC, 8'hCC); wr(4'hD, 8'hBB); wr(4'h6, 8'hAA);
    load();
    chk("R12 stray writes ignored", 32'(count_o), 32'h332211);
    wide_en_i = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule